// File: doc/BRIEF.md
# PLL Retune Sequencer

This block moves one PLL to a new frequency without giving downstream logic a bad clock. A one-cycle start request brings in three divider values: the reference divider, the feedback multiplier and the post divider. The block first checks that the set is legal. A legal set starts a fixed sequence on the PLL control fields. The output is switched to the reference oscillator. The PLL is held in reset while the divider codes and a bandwidth code are loaded. The reset is held for a settle time and then released. The block then waits for the lock flag, and only after lock does it hand the output back to the PLL.

The block runs on the reference clock, so the settle time is counted in reference cycles. The count comes from the reference frequency parameter in MHz. A set that breaks a rule is rejected at once and nothing on the PLL side changes. A PLL that does not lock in time ends the sequence with an error, and the output stays on the oscillator. One result pulse, done or error, ends each accepted request. Busy covers the span from start to that pulse.

Top module: `pll_retune_seq`

## Requirements
- R1: When a legal start is accepted, `pll_mode_o` is 0 (slow, oscillator) in the next cycle while `pll_rst_o` is still 0. `pll_rst_o` rises one cycle later. While `pll_rst_o` is 1, `pll_mode_o` is always 0.
- R2: The divider and bandwidth outputs change only while `pll_rst_o` is high, and never in the first cycle of reset.
- R3: `pll_rst_o` stays high for exactly SETTLE_CYC+1 cycles per sequence, where SETTLE_CYC = REF_MHZ*SETTLE_US.
- R4: The field codes are stored as value minus one: `pll_nr_o` = nr-1, `pll_nf_o` = nf-1, `pll_no_o` = no-1.
- R5: `pll_bw_o` is floor(nf/2)-1.
- R6: `pll_mode_o` goes to 1 (normal) only in the cycle after `lock_i` was seen high. That same cycle carries a one-cycle `done_o`. `done_o` and `err_o` are never high together.
- R7: A start is illegal when any of these holds: nr=0; nf<2; no is neither 1 nor even (no=0 is illegal); REF_KHZ*nf/nr lies outside [VCO_MIN_KHZ, VCO_MAX_KHZ]; REF_KHZ*nf/(nr*no) lies outside [OUT_MIN_KHZ, OUT_MAX_KHZ]. An illegal start gives `err_o` for one cycle in the next cycle. All PLL outputs and `busy_o` stay unchanged.
- R8: If lock is not seen within LOCK_TMO cycles after reset release, `err_o` pulses. `pll_mode_o` stays 0 and `pll_rst_o` stays 0.
- R9: `busy_o` is high from the cycle after an accepted start until the cycle of its `done_o` or `err_o`. A start while busy is ignored and does not queue a second sequence.
- R10: After reset, `pll_mode_o`=0, `pll_rst_o`=0, all field codes are 0, and `busy_o`, `done_o` and `err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Retune request pulse |
| nr_i | input | NR_W | Reference divider value |
| nf_i | input | NF_W | Feedback multiplier value |
| no_i | input | NO_W | Post divider value |
| lock_i | input | 1 | PLL lock flag |
| pll_rst_o | output | 1 | PLL reset |
| pll_mode_o | output | 1 | 0 slow (oscillator), 1 normal (PLL) |
| pll_nr_o | output | NR_W | Reference divider code |
| pll_nf_o | output | NF_W | Feedback multiplier code |
| pll_no_o | output | NO_W | Post divider code |
| pll_bw_o | output | BW_W | Bandwidth code |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished with lock |
| err_o | output | 1 | Illegal request or lock timeout |

## Verification
A grid of reference dividers, multipliers spread over the whole 13-bit range, and every post divider value drives the legality test, the code outputs and the reset length together. It separates sets rejected for divider parity from sets rejected for VCO or output range. Directed requests at the exact VCO limits, and one step past each, confirm that the bounds are inclusive. A lock delay longer than the timeout shows the error path. A start burst during a live sequence shows that the first request's fields survive and that no second sequence runs.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SLOW,
    ST_PROG,
    ST_SETTLE,
    ST_LOCK
  } seq_st_e;

  localparam logic MODE_SLOW   = 1'b0;
  localparam logic MODE_NORMAL = 1'b1;
endpackage

// File: rtl/pll_cfg_check.sv
module pll_cfg_check #(
  parameter int unsigned NR_W        = 6,
  parameter int unsigned NF_W        = 13,
  parameter int unsigned NO_W        = 4,
  parameter int unsigned REF_KHZ     = 24000,
  parameter int unsigned VCO_MIN_KHZ = 440000,
  parameter int unsigned VCO_MAX_KHZ = 2200000,
  parameter int unsigned OUT_MIN_KHZ = 27500,
  parameter int unsigned OUT_MAX_KHZ = 2200000
) (
  input  logic [NR_W-1:0] nr_i,
  input  logic [NF_W-1:0] nf_i,
  input  logic [NO_W-1:0] no_i,
  output logic            legal_o
);
  logic [63:0] f_ref;
  logic [63:0] nr_x;
  logic [63:0] nrno_x;
  logic        div_ok, vco_ok, out_ok;

  always_comb begin
    f_ref  = 64'(REF_KHZ) * 64'(nf_i);
    nr_x   = 64'(nr_i);
    nrno_x = 64'(nr_i) * 64'(no_i);
    div_ok = (nr_i != '0) && (nf_i >= NF_W'(2)) &&
             ((no_i == NO_W'(1)) || ((no_i != '0) && !no_i[0]));
    // compare cross-multiplied to avoid dividers
    vco_ok = (f_ref >= 64'(VCO_MIN_KHZ) * nr_x) &&
             (f_ref <= 64'(VCO_MAX_KHZ) * nr_x);
    out_ok = (f_ref >= 64'(OUT_MIN_KHZ) * nrno_x) &&
             (f_ref <= 64'(OUT_MAX_KHZ) * nrno_x);
    legal_o = div_ok && vco_ok && out_ok;
  end
endmodule

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pll_field_regs.sv
module pll_field_regs #(
  parameter int unsigned NR_W = 6,
  parameter int unsigned NF_W = 13,
  parameter int unsigned NO_W = 4,
  parameter int unsigned BW_W = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [NR_W-1:0] nr_i,
  input  logic [NF_W-1:0] nf_i,
  input  logic [NO_W-1:0] no_i,
  output logic [NR_W-1:0] nr_code_o,
  output logic [NF_W-1:0] nf_code_o,
  output logic [NO_W-1:0] no_code_o,
  output logic [BW_W-1:0] bw_code_o
);
  logic [NF_W-1:0] half_nf;
  assign half_nf = nf_i >> 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nr_code_o <= '0;
      nf_code_o <= '0;
      no_code_o <= '0;
      bw_code_o <= '0;
    end else if (wr_i) begin
      nr_code_o <= nr_i - NR_W'(1);
      nf_code_o <= nf_i - NF_W'(1);
      no_code_o <= no_i - NO_W'(1);
      bw_code_o <= BW_W'(half_nf - NF_W'(1));
    end
  end
endmodule

// File: rtl/pll_retune_seq.sv
module pll_retune_seq
  import pll_seq_pkg::*;
#(
  parameter int unsigned NR_W        = 6,
  parameter int unsigned NF_W        = 13,
  parameter int unsigned NO_W        = 4,
  parameter int unsigned BW_W        = 12,
  parameter int unsigned REF_MHZ     = 24,
  parameter int unsigned SETTLE_US   = 10,
  parameter int unsigned LOCK_TMO    = 4096,
  parameter int unsigned VCO_MIN_KHZ = 440000,
  parameter int unsigned VCO_MAX_KHZ = 2200000,
  parameter int unsigned OUT_MIN_KHZ = 27500,
  parameter int unsigned OUT_MAX_KHZ = 2200000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [NR_W-1:0] nr_i,
  input  logic [NF_W-1:0] nf_i,
  input  logic [NO_W-1:0] no_i,
  input  logic            lock_i,
  output logic            pll_rst_o,
  output logic            pll_mode_o,
  output logic [NR_W-1:0] pll_nr_o,
  output logic [NF_W-1:0] pll_nf_o,
  output logic [NO_W-1:0] pll_no_o,
  output logic [BW_W-1:0] pll_bw_o,
  output logic            busy_o,
  output logic            done_o,
  output logic            err_o
);
  localparam int unsigned REF_KHZ    = REF_MHZ * 1000;
  localparam int unsigned SETTLE_CYC = REF_MHZ * SETTLE_US;
  localparam int unsigned MAX_CYC    = (SETTLE_CYC > LOCK_TMO) ? SETTLE_CYC : LOCK_TMO;
  localparam int unsigned CNT_W      = $clog2(MAX_CYC + 1);

  seq_st_e         st_q;
  logic            legal;
  logic            tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val;
  logic [NR_W-1:0] nr_q;
  logic [NF_W-1:0] nf_q;
  logic [NO_W-1:0] no_q;
  logic            mode_q, rst_q, busy_q, done_q, err_q;

  pll_cfg_check #(
    .NR_W(NR_W), .NF_W(NF_W), .NO_W(NO_W), .REF_KHZ(REF_KHZ),
    .VCO_MIN_KHZ(VCO_MIN_KHZ), .VCO_MAX_KHZ(VCO_MAX_KHZ),
    .OUT_MIN_KHZ(OUT_MIN_KHZ), .OUT_MAX_KHZ(OUT_MAX_KHZ)
  ) u_check (
    .nr_i(nr_i), .nf_i(nf_i), .no_i(no_i), .legal_o(legal)
  );

  // one timer serves both settle and lock windows
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (st_q == ST_PROG) begin
      tmr_load = 1'b1;
      tmr_val  = CNT_W'(SETTLE_CYC - 1);
    end else if (st_q == ST_SETTLE && tmr_zero) begin
      tmr_load = 1'b1;
      tmr_val  = CNT_W'(LOCK_TMO - 1);
    end
  end

  pll_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(tmr_load),
    .load_val_i(tmr_val), .zero_o(tmr_zero)
  );

  pll_field_regs #(
    .NR_W(NR_W), .NF_W(NF_W), .NO_W(NO_W), .BW_W(BW_W)
  ) u_fields (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(st_q == ST_PROG),
    .nr_i(nr_q), .nf_i(nf_q), .no_i(no_q),
    .nr_code_o(pll_nr_o), .nf_code_o(pll_nf_o),
    .no_code_o(pll_no_o), .bw_code_o(pll_bw_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      mode_q <= MODE_SLOW;
      rst_q  <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      nr_q   <= '0;
      nf_q   <= '0;
      no_q   <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          if (legal) begin
            nr_q   <= nr_i;
            nf_q   <= nf_i;
            no_q   <= no_i;
            busy_q <= 1'b1;
            mode_q <= MODE_SLOW;
            st_q   <= ST_SLOW;
          end else begin
            err_q <= 1'b1;
          end
        end
        ST_SLOW: begin
          rst_q <= 1'b1;
          st_q  <= ST_PROG;
        end
        ST_PROG: st_q <= ST_SETTLE;
        ST_SETTLE: if (tmr_zero) begin
          rst_q <= 1'b0;
          st_q  <= ST_LOCK;
        end
        ST_LOCK: begin
          if (lock_i) begin
            mode_q <= MODE_NORMAL;
            done_q <= 1'b1;
            busy_q <= 1'b0;
            st_q   <= ST_IDLE;
          end else if (tmr_zero) begin
            err_q  <= 1'b1;
            busy_q <= 1'b0;
            st_q   <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign pll_rst_o  = rst_q;
  assign pll_mode_o = mode_q;
  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign err_o      = err_q;
endmodule

// File: rtl/pll_retune_seq_chk.sv
module pll_retune_seq_chk #(
  parameter int unsigned NR_W = 6,
  parameter int unsigned NF_W = 13,
  parameter int unsigned NO_W = 4,
  parameter int unsigned BW_W = 12
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            lock_i,
  input logic            pll_rst_o,
  input logic            pll_mode_o,
  input logic [NR_W-1:0] pll_nr_o,
  input logic [NF_W-1:0] pll_nf_o,
  input logic [NO_W-1:0] pll_no_o,
  input logic [BW_W-1:0] pll_bw_o,
  input logic            busy_o,
  input logic            done_o,
  input logic            err_o
);
  logic [NF_W:0]   nf_val;
  logic [BW_W-1:0] bw_exp;
  assign nf_val = {1'b0, pll_nf_o} + (NF_W+1)'(1);
  assign bw_exp = BW_W'((nf_val >> 1) - (NF_W+1)'(1));

  AST_SLOW_IN_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_rst_o |-> (pll_mode_o == 1'b0)); // R1

  AST_FIELDS_IN_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(pll_nr_o) || !$stable(pll_nf_o) || !$stable(pll_no_o) || !$stable(pll_bw_o))
      |-> (pll_rst_o && $past(pll_rst_o))); // R2

  AST_BW_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (pll_bw_o == bw_exp)); // R5

  AST_NORMAL_ON_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pll_mode_o) |-> ($past(lock_i) && done_o)); // R6

  AST_ONE_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o)); // R6

  AST_ILLEGAL_NO_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !$past(busy_o)) |-> ($stable(pll_mode_o) && $stable(pll_nf_o) && !busy_o)); // R7

  AST_TIMEOUT_SLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && $past(busy_o)) |-> (pll_mode_o == 1'b0 && !pll_rst_o)); // R8

  AST_BUSY_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (done_o || err_o)); // R9
endmodule

bind pll_retune_seq pll_retune_seq_chk #(
  .NR_W(NR_W), .NF_W(NF_W), .NO_W(NO_W), .BW_W(BW_W)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .lock_i(lock_i),
  .pll_rst_o(pll_rst_o), .pll_mode_o(pll_mode_o),
  .pll_nr_o(pll_nr_o), .pll_nf_o(pll_nf_o), .pll_no_o(pll_no_o),
  .pll_bw_o(pll_bw_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
);

// File: tb/pll_retune_seq_tb_top.sv
module pll_retune_seq_tb_top;
  localparam int REF_MHZ    = 2;
  localparam int SETTLE_US  = 3;
  localparam int LOCK_TMO   = 20;
  localparam int SETTLE_CYC = REF_MHZ * SETTLE_US;
  localparam longint REF_KHZ = REF_MHZ * 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [5:0]  nr = '0;
  logic [12:0] nf = '0;
  logic [3:0]  no = '0;
  logic lock = 1'b0;
  logic pll_rst, pll_mode, busy, done, err;
  logic [5:0]  c_nr;
  logic [12:0] c_nf;
  logic [3:0]  c_no;
  logic [11:0] c_bw;

  int n_chk = 0;
  int n_fail = 0;
  int lock_dly = 3;
  int lock_cnt = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  pll_retune_seq #(
    .REF_MHZ(REF_MHZ), .SETTLE_US(SETTLE_US), .LOCK_TMO(LOCK_TMO)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .nr_i(nr), .nf_i(nf),
    .no_i(no), .lock_i(lock), .pll_rst_o(pll_rst), .pll_mode_o(pll_mode),
    .pll_nr_o(c_nr), .pll_nf_o(c_nf), .pll_no_o(c_no), .pll_bw_o(c_bw),
    .busy_o(busy), .done_o(done), .err_o(err)
  );

  // behavioural lock: low in reset, high lock_dly cycles after release
  always @(negedge clk) begin
    if (pll_rst) begin
      lock_cnt <= 0;
      lock <= 1'b0;
    end else if (lock_cnt < lock_dly) begin
      lock_cnt <= lock_cnt + 1;
    end else begin
      lock <= 1'b1;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc >= 190000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual %0d expected < 190000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit legal_f(input longint a, input longint b, input longint c);
    longint f;
    f = REF_KHZ * b;
    if (a == 0 || b < 2) return 1'b0;
    if (!(c == 1 || (c != 0 && c % 2 == 0))) return 1'b0;
    if (f < 440000 * a || f > 2200000 * a) return 1'b0;
    if (f < 27500 * a * c || f > 2200000 * a * c) return 1'b0;
    return 1'b1;
  endfunction

  bit     r_done, r_err, r_old_ok;
  int     r_rcnt;

  task automatic run(input int a, input int b, input int c);
    logic [12:0] nf_prev;
    bit first;
    nf_prev = c_nf;
    first = 1'b1;
    r_done = 0; r_err = 0; r_rcnt = 0; r_old_ok = 1;
    @(negedge clk);
    nr = 6'(a); nf = 13'(b); no = 4'(c); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 300; k++) begin
      if (pll_rst) begin
        if (first && c_nf != nf_prev) r_old_ok = 0;
        first = 1'b0;
        r_rcnt++;
      end
      if (done || err) begin
        r_done = done; r_err = err;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic check_legal(input int a, input int b, input int c, input string tag);
    chk(r_done && !r_err, {tag, " R6 done"}, r_done, 1);
    chk(c_nr == 6'(a - 1) && c_nf == 13'(b - 1) && c_no == 4'(c - 1), "R4 codes",
        {c_nr, c_nf, c_no}, {6'(a - 1), 13'(b - 1), 4'(c - 1)});
    chk(c_bw == 12'(b / 2 - 1), "R5 bandwidth", c_bw, b / 2 - 1);
    chk(r_rcnt == SETTLE_CYC + 1, "R3 reset length", r_rcnt, SETTLE_CYC + 1);
    chk(r_old_ok, "R2 fields held in first reset cycle", r_old_ok, 1);
    chk(pll_mode == 1'b1 && !busy, "R6 normal mode", pll_mode, 1);
  endtask

  initial begin
    logic [5:0]  p_nr;
    logic [12:0] p_nf;
    logic [3:0]  p_no;
    logic        p_mode;
    bit          exp_ok;
    int          nr_list[9] = '{1, 2, 3, 4, 7, 9, 16, 31, 63};

    #1;
    chk(pll_mode == 0 && pll_rst == 0 && c_nr == 0 && c_nf == 0 && c_no == 0 &&
        c_bw == 0 && !busy && !done && !err, "R10 reset state", pll_mode, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pll_mode == 0 && !busy && !err && !done, "R10 after reset release", busy, 0);

    // slow-mode entry order
    run(1, 300, 2);
    check_legal(1, 300, 2, "R1");
    @(negedge clk);
    nr = 6'd1; nf = 13'd400; no = 4'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(pll_mode == 0 && pll_rst == 0, "R1 slow before reset", pll_mode, 0);
    chk(busy == 1'b1, "R9 busy after start", busy, 1);
    @(negedge clk);
    chk(pll_rst == 1 && pll_mode == 0, "R1 reset follows slow", pll_rst, 1);
    while (!done && !err) @(negedge clk);
    check_legal(1, 400, 2, "R6");

    // VCO bounds, inclusive
    run(1, 220, 1);  chk(r_done && !r_err, "R7 vco min edge legal", r_err, 0);
    run(1, 219, 1);  chk(r_err && !r_done, "R7 vco below min", r_err, 1);
    run(1, 1100, 1); chk(r_done && !r_err, "R7 vco max edge legal", r_err, 0);
    run(1, 1101, 1); chk(r_err && !r_done, "R7 vco above max", r_err, 1);
    run(1, 400, 3);  chk(r_err, "R7 odd post divider", r_err, 1);
    run(1, 1, 1);    chk(r_err, "R7 multiplier below 2", r_err, 1);

    // lock timeout
    lock_dly = 200;
    run(1, 500, 2);
    chk(r_err && !r_done, "R8 timeout error", r_err, 1);
    chk(pll_mode == 0 && pll_rst == 0 && !busy, "R8 stays slow", pll_mode, 0);
    lock_dly = 3;

    // start while busy
    @(negedge clk);
    nr = 6'd2; nf = 13'd600; no = 4'd4; start = 1'b1;
    @(negedge clk);
    nr = 6'd1; nf = 13'd900; no = 4'd1;
    repeat (5) @(negedge clk);
    start = 1'b0;
    while (!done && !err) @(negedge clk);
    chk(c_nf == 13'd599 && c_nr == 6'd1 && c_no == 4'd3, "R9 first request kept", c_nf, 599);
    repeat (30) @(negedge clk);
    chk(!busy && c_nf == 13'd599, "R9 no queued sequence", busy, 0);

    // grid sweep
    foreach (nr_list[i]) begin
      for (int b = 0; b < 8192; b += 257) begin
        for (int c = 0; c < 16; c++) begin
          p_nr = c_nr; p_nf = c_nf; p_no = c_no; p_mode = pll_mode;
          exp_ok = legal_f(nr_list[i], b, c);
          run(nr_list[i], b, c);
          if (exp_ok) begin
            check_legal(nr_list[i], b, c, "R7 sweep legal");
          end else begin
            chk(r_err && !r_done, "R7 sweep rejected", r_err, 1);
            chk(c_nr == p_nr && c_nf == p_nf && c_no == p_no && pll_mode == p_mode && !busy,
                "R7 sweep no change", c_nf, p_nf);
          end
        end
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule